// File: doc/BRIEF.md
# Byte-Wide Control Register Bank

This block is a small register file of four byte-wide locations, reached over an 8-bit data bus with a 2-bit address, a chip-select strobe and a read/write select. Location 0 holds the configuration bits used by the surrounding buffer and test logic. Locations 1 and 2 give access to the read and write pointer counters, which sit outside the block. A write to either location sends a load strobe and a value to that counter. A read returns the counter's current value, which arrives on a dedicated input. Location 3 is a test data register with a serial input bit and a serial output bit.

The block also contains two test paths. In memory-test mode, the test data register replaces the encoder outputs at the buffer inputs. On every clock, the register captures the output of one encoder, chosen by a channel number and an edge select. In shift mode, the block sends a one-cycle strobe to the selected channel's encode register when an access to location 3 completes, together with the serial input bit. The external data bus is split into a write path, a read path and a drive enable.

Top module: `csr_bank`

## Requirements
- R1: After a synchronous reset, every configuration output is 0, location 0 reads 0x00, and the test data and serial input bits are 0.
- R2: Location 0 layout: bit 0 is the edge select (0 = rising, 1 = falling); bits 2:1 are the test channel; bit 3 enables async auto-increment; bit 4 disables read-pointer sync; bit 5 is memory test; bit 6 is shift enable. Bit 7 always reads 0. The configuration outputs follow the stored bits.
- R3: While chip select and write are both high at address 1, `rptr_load` is high. At address 2, `wptr_load` is high instead. `ptr_load_val` carries data bits 6:0. Neither strobe is high in any other cycle.
- R4: A read of address 1 or 2 returns `{1'b0, rptr_live}` or `{1'b0, wptr_live}` respectively, taken combinationally from the live inputs.
- R5: Location 3 reads as test data in bits 5:0, the serial input bit in bit 6, and in bit 7 the `enc_sout` bit of the selected test channel. A write sets bits 6:0 and ignores bit 7.
- R6: `bus_rdata_oe` is high exactly when chip select is high and write is low.
- R7: An access to location 3 is a run of cycles in which chip select is high at address 3. The access ends in the first cycle without chip select at address 3. If shift is enabled, `shift_strobe` is one-hot on the test channel in exactly that cycle, and it is 0 otherwise. `shift_bit` equals the serial input bit.
- R8: While memory test is set, the test data register loads the selected encoder output on every clock edge, using the rising-edge set when the edge select is 0 and the falling-edge set when it is 1. A bus write to location 3 at the same edge takes priority.
- R9: When memory test is set, every channel's `buf_rise` and `buf_fall` equal the test data register. Otherwise they equal `enc_rise` and `enc_fall`.
- R10: A cycle with chip select low, or with write low, changes no stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | Chip select strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the address |
| bus_rdata_oe | output | 1 | Drive enable for the shared bus |
| cfg_shift_en | output | 1 | Shift mode enable |
| cfg_mem_test | output | 1 | Memory test mode |
| cfg_rp_sync_off | output | 1 | Disable read-pointer sync increment |
| cfg_async_inc_en | output | 1 | Enable read-pointer increment after async readout |
| cfg_test_ch | output | 2 | Test channel |
| cfg_test_fall | output | 1 | Test edge select |
| rptr_load | output | 1 | Read pointer load strobe |
| wptr_load | output | 1 | Write pointer load strobe |
| ptr_load_val | output | 7 | Pointer load value |
| rptr_live | input | 7 | Current read pointer |
| wptr_live | input | 7 | Current write pointer |
| enc_rise | input | 24 | Rising-edge encoder outputs, 6 bits per channel |
| enc_fall | input | 24 | Falling-edge encoder outputs, 6 bits per channel |
| enc_sout | input | 4 | Serial outputs of the encode registers |
| buf_rise | output | 24 | Rising-edge buffer inputs |
| buf_fall | output | 24 | Falling-edge buffer inputs |
| shift_strobe | output | 4 | One-hot shift strobe per channel |
| shift_bit | output | 1 | Serial data for the shift |

## Verification
With memory test enabled, a bus write to location 3 and the per-clock encoder capture both target the test data register at the same edge. The bench provokes this by writing a value unlike the selected encoder output. It then checks the buffer inputs in the cycle after the edge, where the written value must appear. In the cycle after that, the captured encoder value must appear. A second overlap occurs when an access to location 3 is immediately followed by another one. The bench checks that no shift strobe fires between the two accesses and that exactly one strobe follows the last of them.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned N_CH   = 4;
    localparam int unsigned CH_W   = $clog2(N_CH);

    typedef struct packed {
        logic            shift_en;
        logic            mem_test;
        logic            rp_sync_off;
        logic            async_inc_en;
        logic [CH_W-1:0] test_ch;
        logic            test_fall;
    } ctl_t;

    localparam int unsigned CTL_W = $bits(ctl_t);

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_RPTR = 2'd1,
        SEL_WPTR = 2'd2,
        SEL_TEST = 2'd3
    } reg_sel_e;

    function automatic logic [N_CH-1:0] ch_onehot(input logic [CH_W-1:0] ch);
        logic [N_CH-1:0] v;
        v = '0;
        v[ch] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/csr_ctl_reg.sv
module csr_ctl_reg
    import csr_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl
);

    always_ff @(posedge clk) begin
        if (rst)     ctl <= '0;
        else if (we) ctl <= ctl_t'(wdata);
    end

    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
        we |=> (ctl == $past(wdata)));  // R2
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(ctl));  // R10

endmodule

// File: rtl/csr_test_reg.sv
module csr_test_reg #(
    parameter int unsigned EW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [EW-1:0] wdata,
    input  logic          sin_wdata,
    input  logic          capture_en,
    input  logic [EW-1:0] cap_data,
    output logic [EW-1:0] tdr,
    output logic          sin
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tdr <= '0;
            sin <= 1'b0;
        end else if (we) begin
            tdr <= wdata;
            sin <= sin_wdata;
        end else if (capture_en) begin
            tdr <= cap_data;
        end
    end

    AST_TDR_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        we |=> (tdr == $past(wdata)));  // R8
    AST_TDR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (capture_en && !we) |=> (tdr == $past(cap_data)));  // R8
    AST_SIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(sin));  // R10

endmodule

// File: rtl/csr_shift_seq.sv
module csr_shift_seq
    import csr_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_test,
    input  logic            shift_en,
    input  logic [CH_W-1:0] ch,
    output logic [N_CH-1:0] strobe
);

    logic acc_q;
    logic acc_end;

    always_ff @(posedge clk) begin
        if (rst) acc_q <= 1'b0;
        else     acc_q <= acc_test;
    end

    assign acc_end = acc_q && !acc_test;
    assign strobe  = (acc_end && shift_en) ? ch_onehot(ch) : '0;

    AST_SHIFT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe));  // R7
    AST_SHIFT_AT_END: assert property (@(posedge clk) disable iff (rst)
        (|strobe) |-> (!acc_test && $past(acc_test)));  // R7

endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_bank_pkg::*;
#(
    parameter int unsigned PW = 7,
    parameter int unsigned EW = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_cs,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_rdata_oe,
    output logic                 cfg_shift_en,
    output logic                 cfg_mem_test,
    output logic                 cfg_rp_sync_off,
    output logic                 cfg_async_inc_en,
    output logic [CH_W-1:0]      cfg_test_ch,
    output logic                 cfg_test_fall,
    output logic                 rptr_load,
    output logic                 wptr_load,
    output logic [PW-1:0]        ptr_load_val,
    input  logic [PW-1:0]        rptr_live,
    input  logic [PW-1:0]        wptr_live,
    input  logic [N_CH*EW-1:0]   enc_rise,
    input  logic [N_CH*EW-1:0]   enc_fall,
    input  logic [N_CH-1:0]      enc_sout,
    output logic [N_CH*EW-1:0]   buf_rise,
    output logic [N_CH*EW-1:0]   buf_fall,
    output logic [N_CH-1:0]      shift_strobe,
    output logic                 shift_bit
);

    localparam int unsigned SIN_BIT  = DATA_W - 2;
    localparam int unsigned SOUT_BIT = DATA_W - 1;

    reg_sel_e      sel;
    logic          wr_cycle;
    logic          we_ctl;
    logic          we_test;
    logic          acc_test;
    ctl_t          ctl;
    logic [EW-1:0] tdr;
    logic          sin;
    logic [EW-1:0] cap_data;
    logic [DATA_W-1:0] rd_mux;

    assign sel      = reg_sel_e'(bus_addr);
    assign wr_cycle = bus_cs && bus_wr;
    assign we_ctl   = wr_cycle && (sel == SEL_CTL);
    assign we_test  = wr_cycle && (sel == SEL_TEST);
    assign acc_test = bus_cs && (sel == SEL_TEST);

    assign rptr_load    = wr_cycle && (sel == SEL_RPTR);
    assign wptr_load    = wr_cycle && (sel == SEL_WPTR);
    assign ptr_load_val = bus_wdata[PW-1:0];

    csr_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (we_ctl),
        .wdata (bus_wdata[CTL_W-1:0]),
        .ctl   (ctl)
    );

    assign cap_data = ctl.test_fall ? enc_fall[ctl.test_ch*EW +: EW]
                                    : enc_rise[ctl.test_ch*EW +: EW];

    csr_test_reg #(.EW(EW)) u_test (
        .clk        (clk),
        .rst        (rst),
        .we         (we_test),
        .wdata      (bus_wdata[EW-1:0]),
        .sin_wdata  (bus_wdata[SIN_BIT]),
        .capture_en (ctl.mem_test),
        .cap_data   (cap_data),
        .tdr        (tdr),
        .sin        (sin)
    );

    csr_shift_seq u_shift (
        .clk      (clk),
        .rst      (rst),
        .acc_test (acc_test),
        .shift_en (ctl.shift_en),
        .ch       (ctl.test_ch),
        .strobe   (shift_strobe)
    );

    assign shift_bit = sin;

    for (genvar c = 0; c < N_CH; c++) begin : g_buf
        assign buf_rise[c*EW +: EW] = ctl.mem_test ? tdr : enc_rise[c*EW +: EW];
        assign buf_fall[c*EW +: EW] = ctl.mem_test ? tdr : enc_fall[c*EW +: EW];
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_CTL:  rd_mux[CTL_W-1:0] = ctl;
            SEL_RPTR: rd_mux[PW-1:0]    = rptr_live;
            SEL_WPTR: rd_mux[PW-1:0]    = wptr_live;
            SEL_TEST: begin
                rd_mux[EW-1:0]   = tdr;
                rd_mux[SIN_BIT]  = sin;
                rd_mux[SOUT_BIT] = enc_sout[ctl.test_ch];
            end
            default:  rd_mux = '0;
        endcase
    end

    assign bus_rdata    = rd_mux;
    assign bus_rdata_oe = bus_cs && !bus_wr;

    assign cfg_shift_en     = ctl.shift_en;
    assign cfg_mem_test     = ctl.mem_test;
    assign cfg_rp_sync_off  = ctl.rp_sync_off;
    assign cfg_async_inc_en = ctl.async_inc_en;
    assign cfg_test_ch      = ctl.test_ch;
    assign cfg_test_fall    = ctl.test_fall;

    AST_LOAD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rptr_load || wptr_load) |-> (bus_cs && bus_wr));  // R3
    AST_BUF_TEST_PATH: assert property (@(posedge clk) disable iff (rst)
        (cfg_mem_test && !$past(we_test) && $past(cfg_mem_test))
            |-> (buf_rise[EW-1:0] == $past(cap_data)));  // R9

endmodule

// File: tb/tb_csr_bank.sv
module tb_csr_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cs = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_oe;
    logic        cfg_shift_en, cfg_mem_test, cfg_rp_sync_off, cfg_async_inc_en, cfg_test_fall;
    logic [1:0]  cfg_test_ch;
    logic        rptr_load, wptr_load;
    logic [6:0]  ptr_load_val;
    logic [6:0]  rptr_live = '0, wptr_live = '0;
    logic [23:0] enc_rise = '0, enc_fall = '0;
    logic [3:0]  enc_sout = '0;
    logic [23:0] buf_rise, buf_fall;
    logic [3:0]  shift_strobe;
    logic        shift_bit;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct { logic [7:0] exp; string tag; } rd_item_t;
    rd_item_t rd_q[$];

    always #2 clk = ~clk;

    csr_bank dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data and compares at the falling edge
    always @(negedge clk) begin
        if (!rst && bus_cs && !bus_wr) begin
            if (rd_q.size() == 0) begin
                chk(1'b0, "R4 unexpected read", {24'b0, bus_rdata}, 32'h0);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                chk(bus_rdata == it.exp, it.tag, {24'b0, bus_rdata}, {24'b0, it.exp});
                chk(bus_rdata_oe == 1'b1, "R6 oe during read", {31'b0, bus_rdata_oe}, 32'h1);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag;
        rd_q.push_back(it);
        bus_cs = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_cs = 1'b0;
    endtask

    initial begin
        #400000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        @(negedge clk);
        chk({cfg_shift_en, cfg_mem_test, cfg_rp_sync_off, cfg_async_inc_en, cfg_test_ch, cfg_test_fall} == 7'h0,
            "R1 cfg outputs after reset",
            {25'b0, cfg_shift_en, cfg_mem_test, cfg_rp_sync_off, cfg_async_inc_en, cfg_test_ch, cfg_test_fall}, 0);
        chk(bus_rdata_oe == 1'b0, "R6 oe idle", {31'b0, bus_rdata_oe}, 0);
        @(posedge clk); #1;
        bus_read(2'd0, 8'h00, "R1 reg0 after reset");
        bus_read(2'd3, 8'h00, "R1 reg3 after reset");

        // R2 layout and bit 7
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, 8'h7F, "R2 reg0 bit7 reads 0");
        bus_write(2'd0, 8'h15);
        @(negedge clk);
        chk(cfg_test_ch == 2'd2 && cfg_test_fall && cfg_rp_sync_off && !cfg_async_inc_en
            && !cfg_mem_test && !cfg_shift_en, "R2 fields from 0x15",
            {25'b0, cfg_shift_en, cfg_mem_test, cfg_rp_sync_off, cfg_async_inc_en, cfg_test_ch, cfg_test_fall}, 32'h15);
        @(posedge clk); #1;
        bus_read(2'd0, 8'h15, "R2 reg0 readback");

        // R10 cycles without chip select or without write
        bus_cs = 1'b0; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hAA;
        idle(1);
        bus_wr = 1'b0; bus_addr = 2'd3; bus_wdata = 8'h55;
        idle(1);
        bus_read(2'd0, 8'h15, "R10 reg0 unchanged");
        bus_read(2'd3, 8'h00, "R10 reg3 unchanged");

        // R3 pointer load strobes
        bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h5A;
        @(negedge clk);
        chk(rptr_load && !wptr_load && ptr_load_val == 7'h5A, "R3 read pointer load",
            {23'b0, rptr_load, wptr_load, ptr_load_val}, {23'b0, 2'b10, 7'h5A});
        chk(bus_rdata_oe == 1'b0, "R6 oe during write", {31'b0, bus_rdata_oe}, 0);
        bus_addr = 2'd2; bus_wdata = 8'h8C;
        #0.5;
        chk(!rptr_load && wptr_load && ptr_load_val == 7'h0C, "R3 write pointer load",
            {23'b0, rptr_load, wptr_load, ptr_load_val}, {23'b0, 2'b01, 7'h0C});
        @(posedge clk); #1;
        bus_cs = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        chk(!rptr_load && !wptr_load, "R3 no strobe when idle", {30'b0, rptr_load, wptr_load}, 0);
        @(posedge clk); #1;

        // R4 live pointer readback
        rptr_live = 7'h33; wptr_live = 7'h7F;
        bus_read(2'd1, 8'h33, "R4 read pointer live");
        bus_read(2'd2, 8'h7F, "R4 write pointer live");
        rptr_live = 7'h01;
        bus_read(2'd1, 8'h01, "R4 read pointer follows input");

        // R5 location 3 layout
        bus_write(2'd0, 8'h00);
        enc_sout = 4'b0100;
        bus_write(2'd3, 8'hEA);
        bus_read(2'd3, 8'h6A, "R5 reg3 ch0 sout, bit7 not stored");
        bus_write(2'd0, 8'h04);
        bus_read(2'd3, 8'hEA, "R5 reg3 ch2 sout");

        // R7 shift strobe after back-to-back accesses
        bus_write(2'd0, 8'h44);
        begin
            rd_item_t it;
            it.exp = 8'hEA; it.tag = "R7 reg3 first access";
            rd_q.push_back(it);
            it.tag = "R7 reg3 second access";
            rd_q.push_back(it);
        end
        bus_cs = 1'b1; bus_wr = 1'b0; bus_addr = 2'd3;
        @(posedge clk); #1;
        @(negedge clk);
        chk(shift_strobe == 4'b0000, "R7 no strobe mid access", {28'b0, shift_strobe}, 0);
        @(posedge clk); #1;
        bus_cs = 1'b0;
        @(negedge clk);
        chk(shift_strobe == 4'b0100 && shift_bit == 1'b1, "R7 strobe at end of access",
            {27'b0, shift_bit, shift_strobe}, {27'b0, 1'b1, 4'b0100});
        @(posedge clk); #1;
        @(negedge clk);
        chk(shift_strobe == 4'b0000, "R7 strobe lasts one cycle", {28'b0, shift_strobe}, 0);
        @(posedge clk); #1;
        bus_write(2'd0, 8'h04);
        bus_read(2'd3, 8'hEA, "R7 reg3 access with shift off");
        @(negedge clk);
        chk(shift_strobe == 4'b0000, "R7 no strobe with shift off", {28'b0, shift_strobe}, 0);
        @(posedge clk); #1;

        // R9 direct path when memory test is off
        enc_rise = 24'hABCDEF; enc_fall = 24'h123456;
        @(negedge clk);
        chk(buf_rise == enc_rise && buf_fall == enc_fall, "R9 buffers follow encoders",
            {8'b0, buf_rise}, {8'b0, enc_rise});
        @(posedge clk); #1;

        // R8 capture of selected encoder, falling set, channel 1
        enc_rise[11:6] = 6'h2E; enc_fall[11:6] = 6'h15; enc_sout = 4'b0000;
        bus_write(2'd0, 8'h23);
        idle(1);
        bus_read(2'd3, 8'h55, "R8 capture fall ch1");
        @(negedge clk);
        chk(buf_rise[23:18] == 6'h15 && buf_fall[5:0] == 6'h15, "R9 buffers carry test data",
            {26'b0, buf_rise[23:18]}, 32'h15);
        @(posedge clk); #1;

        // R8 bus write wins over capture at the same edge
        bus_write(2'd3, 8'h0B);
        @(negedge clk);
        chk(buf_rise[5:0] == 6'h0B, "R8 write wins over capture", {26'b0, buf_rise[5:0]}, 32'h0B);
        @(posedge clk); #1;
        @(negedge clk);
        chk(buf_rise[5:0] == 6'h15, "R8 capture resumes", {26'b0, buf_rise[5:0]}, 32'h15);
        @(posedge clk); #1;

        // R8 rising set selection
        bus_write(2'd0, 8'h22);
        idle(1);
        bus_read(2'd3, 8'h2E, "R8 capture rise ch1");

        idle(2);
        chk(rd_q.size() == 0, "R4 all reads observed", rd_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule